// File: doc/BRIEF.md
# Global Interrupt Gate Controller

This block is the per-processor gate through which all interrupt traffic must pass. A single gate flag covers four sources: ordinary device interrupts, non-maskable interrupts, system-management interrupts and INIT. While the gate is closed, every request is latched in a one-bit pending slot for its source. When software opens the gate, the latched requests drain out as a delivery strobe with a type code, one per cycle, highest priority first.

Two further events act on the gate and on three control flags: a secure-launch command and a startup interprocessor interrupt. The control flags are debug-disable, INIT-redirect and A20-mask-disable.

- **Secure launch.** The secure-launch command closes the gate.
- **Startup IPI.** A startup IPI always publishes a 20-bit start address built from its 8-bit vector. If the boot processor has reported a secure launch, the startup IPI also closes the gate and sets all three control flags.
- **INIT redirect.** While the INIT-redirect flag is set, an INIT that is not intercepted is not delivered as INIT. It leaves instead as a security-exception request with a fixed vector and error code.

Top module: `intr_gate_ctl`

## Requirements
- R1: While the gate is closed, `dlv_valid` and `sx_valid` stay 0, whatever requests arrive.
- R2: Each source has one pending bit. A request sets it in the next cycle. Several requests of one type made while it is pending produce a single delivery.
- R3: While the gate is open, pending sources are delivered one per cycle in the order INIT, SMI, NMI, device. Type codes are 3 = INIT, 2 = SMI, 1 = NMI, 0 = device. Each delivery clears its own pending bit.
- R4: `gate_clr` closes the gate from the next cycle and `gate_set` opens it from the next cycle. When both are asserted in the same cycle, the gate ends up closed.
- R5: `launch_cmd` closes the gate from the next cycle.
- R6: A granted INIT with the INIT-redirect flag at 1 and `init_intercept` at 0 raises `sx_valid` with `sx_vector` = 30 and `sx_errcode` = 1, and gives no `dlv_valid`.
- R7: A granted INIT with the INIT-redirect flag at 0, or with `init_intercept` at 1, is delivered as type code 3.
- R8: A startup IPI with `bsp_launched` at 1 closes the gate and sets `dbg_off`, `init_redir` and `a20_unmask`, all from the next cycle.
- R9: A startup IPI with `bsp_launched` at 0 leaves the gate and the three flags unchanged.
- R10: On every startup IPI, `start_addr` becomes {vector, 12'h000} in the next cycle. The vector forms bits 19:12.
- R11: After reset the gate is open, nothing is pending, the three flags are 0 and `start_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | 1 | Device interrupt request pulse |
| nmi_req | input | 1 | NMI request pulse |
| smi_req | input | 1 | SMI request pulse |
| init_req | input | 1 | INIT request pulse |
| init_intercept | input | 1 | INIT is intercepted and must not be redirected |
| gate_set | input | 1 | Open the gate |
| gate_clr | input | 1 | Close the gate |
| launch_cmd | input | 1 | Secure-launch command, closes the gate |
| bsp_launched | input | 1 | Boot processor reports a secure launch |
| sipi_valid | input | 1 | Startup IPI event |
| sipi_vec | input | 8 | Startup IPI vector |
| gate_open | output | 1 | Current gate state |
| dlv_valid | output | 1 | Interrupt delivered this cycle |
| dlv_kind | output | 2 | Delivered type code |
| sx_valid | output | 1 | Security-exception request |
| sx_vector | output | 8 | Security-exception vector |
| sx_errcode | output | 16 | Security-exception error code |
| start_addr | output | 20 | Startup physical address |
| dbg_off | output | 1 | Debug-disable flag |
| init_redir | output | 1 | INIT-redirect flag |
| a20_unmask | output | 1 | A20-mask-disable flag |

## Verification
The assertions check, on every cycle, the properties that can be stated locally:

- a request lands in its pending bit;
- at most one source is granted per cycle, and only a pending one;
- a close or launch command silences the gate in the next cycle;
- a security exception only appears while redirection is armed;
- the start address tracks the startup vector.

Only the bench scenarios can show the effects that span many cycles. These are the exact drain order after the gate reopens, that duplicates collapse into one delivery, and that the same INIT changes form depending on the flags set by an earlier startup IPI.

// File: rtl/gig_pkg.sv
package gig_pkg;

    localparam int NSRC = 4;

    typedef enum logic [1:0] {
        IK_DEV  = 2'd0,
        IK_NMI  = 2'd1,
        IK_SMI  = 2'd2,
        IK_INIT = 2'd3
    } irq_kind_t;

    typedef struct packed {
        logic dbg_off;
        logic init_redir;
        logic a20_unmask;
    } ctl_flags_t;

    localparam ctl_flags_t FLAGS_CLEAR  = '{dbg_off: 1'b0, init_redir: 1'b0, a20_unmask: 1'b0};
    localparam ctl_flags_t FLAGS_SECURE = '{dbg_off: 1'b1, init_redir: 1'b1, a20_unmask: 1'b1};

    function automatic irq_kind_t kind_of(input logic [1:0] idx);
        return irq_kind_t'(idx);
    endfunction

endpackage

// File: rtl/gig_pend.sv
module gig_pend #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= 1'b1;
            else if (clr[i])
                q[i] <= 1'b0;
        end

        AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> q[i]) else $error("request not latched"); // R2
    end

endmodule

// File: rtl/gig_pick.sv
module gig_pick #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             en,
    output logic [N-1:0]     grant,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
        grant = (en && any) ? (N'(1) << idx) : '0;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)) else $error("multiple grants"); // R3
    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0) else $error("grant without request"); // R3

endmodule

// File: rtl/intr_gate_ctl.sv
module intr_gate_ctl
    import gig_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int ADDR_W    = 20,
    parameter int ERR_W     = 16,
    parameter int SX_VECNUM = 30,
    parameter int SX_ERR    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_req,
    input  logic              nmi_req,
    input  logic              smi_req,
    input  logic              init_req,
    input  logic              init_intercept,
    input  logic              gate_set,
    input  logic              gate_clr,
    input  logic              launch_cmd,
    input  logic              bsp_launched,
    input  logic              sipi_valid,
    input  logic [VEC_W-1:0]  sipi_vec,
    output logic              gate_open,
    output logic              dlv_valid,
    output logic [1:0]        dlv_kind,
    output logic              sx_valid,
    output logic [VEC_W-1:0]  sx_vector,
    output logic [ERR_W-1:0]  sx_errcode,
    output logic [ADDR_W-1:0] start_addr,
    output logic              dbg_off,
    output logic              init_redir,
    output logic              a20_unmask
);

    localparam int OFF_W = ADDR_W - VEC_W;

    logic [NSRC-1:0] req_vec, pend_q, grant;
    logic            any_pend;
    logic [1:0]      win_idx;
    logic            gate_q;
    ctl_flags_t      flags_q;
    logic            secure_sipi, close_now, redirect;

    assign req_vec = {init_req, smi_req, nmi_req, dev_req};

    gig_pend #(.N(NSRC)) u_pend (
        .clk (clk),
        .rst (rst),
        .set (req_vec),
        .clr (grant),
        .q   (pend_q)
    );

    gig_pick #(.N(NSRC)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .req   (pend_q),
        .en    (gate_q),
        .grant (grant),
        .any   (any_pend),
        .idx   (win_idx)
    );

    assign secure_sipi = sipi_valid && bsp_launched;
    assign close_now   = gate_clr || launch_cmd || secure_sipi;

    always_ff @(posedge clk) begin
        if (rst)
            gate_q <= 1'b1;
        else if (close_now)
            gate_q <= 1'b0;
        else if (gate_set)
            gate_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= FLAGS_CLEAR;
        else if (secure_sipi)
            flags_q <= FLAGS_SECURE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            start_addr <= '0;
        else if (sipi_valid)
            start_addr <= {sipi_vec, {OFF_W{1'b0}}};
    end

    assign redirect   = (kind_of(win_idx) == IK_INIT) && flags_q.init_redir && !init_intercept;
    assign dlv_valid  = gate_q && any_pend && !redirect;
    assign dlv_kind   = win_idx;
    assign sx_valid   = gate_q && any_pend && redirect;
    assign sx_vector  = VEC_W'(SX_VECNUM);
    assign sx_errcode = ERR_W'(SX_ERR);
    assign gate_open  = gate_q;
    assign dbg_off    = flags_q.dbg_off;
    assign init_redir = flags_q.init_redir;
    assign a20_unmask = flags_q.a20_unmask;

    AST_CLOSE_SILENCES: assert property (@(posedge clk) disable iff (rst)
        gate_clr |=> !dlv_valid && !sx_valid) else $error("delivery while closed"); // R1
    AST_LAUNCH_CLOSES: assert property (@(posedge clk) disable iff (rst)
        launch_cmd |=> !gate_open) else $error("launch left gate open"); // R5
    AST_SECURE_SIPI: assert property (@(posedge clk) disable iff (rst)
        sipi_valid && bsp_launched |=> !gate_open && dbg_off && init_redir && a20_unmask)
        else $error("secure startup effects missing"); // R8
    AST_SX_ARMED: assert property (@(posedge clk) disable iff (rst)
        sx_valid |-> init_redir && !init_intercept && !dlv_valid) else $error("stray exception"); // R6
    AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
        sipi_valid |=> start_addr == {$past(sipi_vec), {OFF_W{1'b0}}}) else $error("bad start address"); // R10

endmodule

// File: tb/intr_gate_ctl_test.sv
module intr_gate_ctl_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dev_req = 0, nmi_req = 0, smi_req = 0, init_req = 0, init_intercept = 0;
    logic gate_set = 0, gate_clr = 0, launch_cmd = 0, bsp_launched = 0, sipi_valid = 0;
    logic [7:0]  sipi_vec = '0;
    logic        gate_open, dlv_valid, sx_valid, dbg_off, init_redir, a20_unmask;
    logic [1:0]  dlv_kind;
    logic [7:0]  sx_vector;
    logic [15:0] sx_errcode;
    logic [19:0] start_addr;

    int n_chk = 0, n_bad = 0;
    int exp_q[$];       // 0..3 = delivery type code, 4 = security exception
    bit done = 0;

    always #4 clk = ~clk;

    intr_gate_ctl uut (
        .clk(clk), .rst(rst), .dev_req(dev_req), .nmi_req(nmi_req), .smi_req(smi_req),
        .init_req(init_req), .init_intercept(init_intercept), .gate_set(gate_set),
        .gate_clr(gate_clr), .launch_cmd(launch_cmd), .bsp_launched(bsp_launched),
        .sipi_valid(sipi_valid), .sipi_vec(sipi_vec), .gate_open(gate_open),
        .dlv_valid(dlv_valid), .dlv_kind(dlv_kind), .sx_valid(sx_valid),
        .sx_vector(sx_vector), .sx_errcode(sx_errcode), .start_addr(start_addr),
        .dbg_off(dbg_off), .init_redir(init_redir), .a20_unmask(a20_unmask)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_item(input int item);
        exp_q.push_back(item);
    endtask

    // Monitor: pops the scoreboard whenever the design produces a result
    always @(negedge clk) begin
        if (!rst) begin
            if (dlv_valid || sx_valid) begin
                int got;
                got = sx_valid ? 4 : int'(dlv_kind);
                check("R3 single output per cycle", int'(dlv_valid && sx_valid), 0);
                if (exp_q.size() == 0) begin
                    check("R1 unexpected output", got, -1);
                end else begin
                    int want;
                    want = exp_q.pop_front();
                    check("R3 delivery order", got, want);
                end
                if (sx_valid) begin
                    check("R6 exception vector", int'(sx_vector), 30);
                    check("R6 exception errcode", int'(sx_errcode), 1);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 50) begin
            @(negedge clk);
            t++;
        end
        check(req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        // Reset state
        check("R11 gate open", int'(gate_open), 1);
        check("R11 no delivery", int'(dlv_valid | sx_valid), 0);
        check("R11 flags", int'({dbg_off, init_redir, a20_unmask}), 0);
        check("R11 start addr", int'(start_addr), 0);

        // Open gate: single device request
        expect_item(0);
        pulse(dev_req);
        drain("R3 device delivered");

        // Closed gate: everything held, duplicates merge
        pulse(gate_clr);
        check("R4 gate closed", int'(gate_open), 0);
        dev_req = 1; nmi_req = 1; smi_req = 1; init_req = 1;
        tick(1);
        dev_req = 0; nmi_req = 0; smi_req = 0; init_req = 0;
        pulse(dev_req);
        pulse(nmi_req);
        tick(5);
        check("R1 nothing while closed", int'(dlv_valid | sx_valid), 0);
        check("R2 no early release", exp_q.size(), 0);
        expect_item(3); expect_item(2); expect_item(1); expect_item(0);
        pulse(gate_set);
        check("R4 gate reopened", int'(gate_open), 1);
        drain("R3 priority drain");
        tick(3);
        check("R2 duplicates merged", int'(dlv_valid), 0);

        // Set and clear together: closed wins
        gate_set = 1; gate_clr = 1;
        tick(1);
        gate_set = 0; gate_clr = 0;
        check("R4 clear wins", int'(gate_open), 0);
        pulse(gate_set);

        // Launch closes gate
        pulse(launch_cmd);
        check("R5 launch closes", int'(gate_open), 0);
        pulse(nmi_req);
        tick(3);
        expect_item(1);
        pulse(gate_set);
        drain("R5 held NMI released");

        // Startup IPI without secure launch
        sipi_vec = 8'h9A;
        pulse(sipi_valid);
        check("R10 start addr", int'(start_addr), 32'h9A000);
        check("R9 gate untouched", int'(gate_open), 1);
        check("R9 flags untouched", int'({dbg_off, init_redir, a20_unmask}), 0);

        // INIT with redirect flag clear
        expect_item(3);
        pulse(init_req);
        drain("R7 plain INIT");

        // Startup IPI with secure launch
        bsp_launched = 1;
        sipi_vec = 8'h07;
        pulse(sipi_valid);
        bsp_launched = 0;
        check("R10 start addr secure", int'(start_addr), 32'h07000);
        check("R8 gate closed", int'(gate_open), 0);
        check("R8 flags set", int'({dbg_off, init_redir, a20_unmask}), 7);

        // INIT redirected into security exception
        pulse(init_req);
        tick(2);
        check("R1 INIT held", int'(sx_valid | dlv_valid), 0);
        expect_item(4);
        pulse(gate_set);
        drain("R6 redirected INIT");

        // Intercepted INIT is not redirected
        init_intercept = 1;
        tick(1);
        expect_item(3);
        pulse(init_req);
        drain("R7 intercepted INIT");
        init_intercept = 0;

        tick(2);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule